// File: doc/BRIEF.md
# Li-Ion Charge Sequencing Controller

This block is the digital sequencer of a single-cell constant-current / constant-voltage charger. It reads synchronous comparator flags: input supply valid, battery below the pre-charge threshold, battery at float voltage, charge current below the termination level, battery below the recharge level, battery below 1 V, battery temperature out of range, die thermal warning and overcharge. From these it decides which charging phase the analog loops should run. It also requests half current during a die thermal warning and drives an open-drain status flag whose blink rate encodes the most urgent condition.

Every duration is a count of `tick` pulses, one per millisecond in silicon. The parameters hold the counts, so a test can shorten them. Each transition that depends on a comparator level passes through its own deglitch counter. The counter clears as soon as the level drops or the transition stops being possible. A single timeout counter restarts on entry to pre-charge and again on entry to fast charge. It keeps running while charging is paused for temperature.

States: `ST_IDLE` (not charging), `ST_PRE` (pre-charge CC), `ST_FAST` (fast CC), `ST_CV` (constant voltage), `ST_DONE` (end of charge), `ST_F_TO` (timeout fault), `ST_F_LOW` (fell below pre-charge threshold during fast/CV), `ST_F_OVC` (overcharge), `ST_F_DEAD` (battery held below 1 V).

Transitions:
- start: IDLE to PRE or FAST.
- promote: PRE to FAST.
- float: FAST to CV.
- terminate: CV to DONE.
- recharge: DONE to PRE or FAST.
- timeout: PRE/FAST/CV to F_TO.
- sag: FAST/CV to F_LOW.
- dead: PRE to F_DEAD.
- overcharge: any state to F_OVC.
- disable: any non-overcharge state to IDLE when enable is low.
- unplug: any state to IDLE when the input is invalid.

Top module: `chg_seq_ctrl`

## Requirements
- R1: After reset, and one clock after `in_ok` is low, `phase` reads OFF (0) and `flag_pull_lo` is 0 (flag released). `half_cur` is 0 after reset.
- R2: With `in_ok` and `chg_en` high, IDLE starts a cycle on the next clock: PRE (`phase`=1) if `bat_lt_pre` is 1, otherwise FAST (`phase`=2).
- R3: PRE moves to FAST only after `bat_lt_pre` has read 0 for PRE_DG consecutive ticks. A shorter excursion has no effect.
- R4: A cycle ends in fault (`phase`=5) after PRE_TO ticks spent in PRE, or after FAST_TO ticks counted from entry to FAST through FAST and CV. Ticks during a temperature pause also count.
- R5: In FAST or CV, `bat_lt_pre` held 1 for LOW_DG ticks gives a fault (`phase`=5). A shorter dip has no effect.
- R6: In PRE, FAST or CV, `temp_bad` held for TEMP_DG ticks pauses charging (`phase`=0). The same state resumes when `temp_bad` clears.
- R7: `chg_en` low forces IDLE (`phase`=0) and drives the flag low steadily. Raising it again restarts a cycle from a timeout fault, a sag fault, a dead-battery fault or DONE.
- R8: FAST enters CV (`phase`=3) when `bat_at_float` is 1. CV enters DONE (`phase`=4) after `i_lt_term` has been 1 for EOC_DG ticks, but only when `term_en` is 1. With `term_en` 0, CV continues.
- R9: In DONE with `rech_en` 1, `bat_lt_rech` held for RECH_DG ticks starts a new cycle. With `rech_en` 0, or a shorter dip, DONE remains.
- R10: `ovchg` with `in_ok` high gives a fault (`phase`=5) on the next clock. That fault ignores `chg_en` and clears only when `in_ok` goes low.
- R11: In PRE, `bat_lt_1v` held for DEAD_DG ticks gives a fault (`phase`=5) with the flag driven low steadily.
- R12: `half_cur` is 1 exactly when `die_warm` is 1 and the block is in unpaused PRE or FAST.
- R13: While blinking, the flag toggles every TICKS_PER_S*10/(2*F) ticks, where F is the rate in tenths of Hz. The rates are 162 for temperature pause, 142 for die warning while charging, 128 for sag fault, 102 for timeout, 82 for overcharge, 62 for charging and 41 for DONE. When several apply, the highest rate wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle time base pulse (1 ms) |
| in_ok | input | 1 | Input supply valid |
| chg_en | input | 1 | Charger enable pin, active high |
| term_en | input | 1 | Termination enable (configuration) |
| rech_en | input | 1 | Auto-recharge enable |
| bat_lt_pre | input | 1 | Battery below pre-charge threshold |
| bat_at_float | input | 1 | Battery at float voltage |
| i_lt_term | input | 1 | Charge current below termination level |
| bat_lt_rech | input | 1 | Battery below recharge level |
| bat_lt_1v | input | 1 | Battery below 1 V |
| temp_bad | input | 1 | Battery temperature out of range |
| die_warm | input | 1 | Die thermal warning |
| ovchg | input | 1 | Battery overcharge detected |
| phase | output | 3 | 0 off, 1 pre, 2 fast, 3 CV, 4 done, 5 fault |
| half_cur | output | 1 | Request half programmed current |
| flag_pull_lo | output | 1 | 1 pulls the open-drain status flag low |

## Verification
The bench targets deglitch boundaries: an excursion one or two ticks short of each filter length must leave the phase alone. A filter that failed to clear on a glitch would promote or fault early. The timeout is measured across a temperature pause, so a timer that froze while paused would stay in pre-charge past the limit. It also probes the overcharge fault against enable toggles, and termination with `term_en` low, where a wrong design would drop out of overcharge or end the cycle. Blink half-periods are measured for every source, which catches a swapped rate or a lost priority. Random traffic checks unplug, overcharge latching and the half-current condition every cycle.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;

    typedef enum logic [2:0] {
        PH_OFF   = 3'd0,
        PH_PRE   = 3'd1,
        PH_FAST  = 3'd2,
        PH_CV    = 3'd3,
        PH_DONE  = 3'd4,
        PH_FAULT = 3'd5
    } phase_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PRE, ST_FAST, ST_CV, ST_DONE,
        ST_F_TO, ST_F_LOW, ST_F_OVC, ST_F_DEAD
    } state_e;

    typedef enum logic [1:0] {FM_REL, FM_LOW, FM_BLINK} flag_mode_e;

    typedef enum logic [2:0] {
        BL_EOC, BL_CHG, BL_OVC, BL_TO, BL_LOW, BL_WARM, BL_TEMP
    } blink_e;

    localparam int NUM_DG  = 6;
    localparam int DG_UP   = 0;
    localparam int DG_LOW  = 1;
    localparam int DG_EOC  = 2;
    localparam int DG_TEMP = 3;
    localparam int DG_RECH = 4;
    localparam int DG_DEAD = 5;

    // blink rate in tenths of Hz
    function automatic int unsigned blink_f10(blink_e b);
        case (b)
            BL_EOC:  return 41;
            BL_CHG:  return 62;
            BL_OVC:  return 82;
            BL_TO:   return 102;
            BL_LOW:  return 128;
            BL_WARM: return 142;
            default: return 162;
        endcase
    endfunction

endpackage

// File: rtl/chg_dglt.sv
module chg_dglt #(
    parameter int unsigned LEN = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic arm,
    input  logic cond,
    output logic done
);
    localparam int unsigned CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!arm || !cond) begin
            cnt <= '0;
        end else if (tick && cnt != CW'(LEN)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt == CW'(LEN));

    // R3 (and every filtered transition): completion only follows an armed, asserted level
    a_r3_filter_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(arm && cond));

endmodule

// File: rtl/chg_tmo.sv
module chg_tmo #(
    parameter int unsigned MAXV = 1000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick,
    input  logic                        clr,
    input  logic                        run,
    output logic [$clog2(MAXV+1)-1:0]   cnt
);
    localparam int unsigned TW = $clog2(MAXV + 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (run && tick && cnt != TW'(MAXV)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R4: the timeout count only moves while a charging state is active
    a_r4_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(cnt));

endmodule

// File: rtl/chg_blink.sv
module chg_blink
    import chg_seq_pkg::*;
#(
    parameter int unsigned TICKS_PER_S = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  flag_mode_e mode,
    input  blink_e     sel,
    output logic       pull_lo
);
    localparam int unsigned HMAX = (TICKS_PER_S * 10) / (2 * 41) + 1;
    localparam int unsigned HW   = $clog2(HMAX + 1);

    function automatic logic [HW-1:0] half_of(blink_e b);
        return HW'((TICKS_PER_S * 10) / (2 * blink_f10(b)));
    endfunction

    logic [HW-1:0] cnt;
    logic [HW-1:0] half_q;
    blink_e        sel_q;
    logic          lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            half_q <= HW'(HMAX);
            sel_q  <= BL_EOC;
            lvl    <= 1'b1;
        end else if (mode != FM_BLINK || sel != sel_q) begin
            cnt    <= '0;
            half_q <= half_of(sel);
            sel_q  <= sel;
            lvl    <= 1'b1;
        end else if (tick) begin
            if (cnt == half_q - 1'b1) begin
                cnt <= '0;
                lvl <= ~lvl;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign pull_lo = (mode == FM_LOW) || (mode == FM_BLINK && lvl);

    // R13: the half-period counter never runs past the selected half period
    a_r13_cnt_below_half: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < half_q);

endmodule

// File: rtl/chg_seq_ctrl.sv
module chg_seq_ctrl
    import chg_seq_pkg::*;
#(
    parameter int unsigned TICKS_PER_S = 1000,
    parameter int unsigned PRE_DG      = 100,
    parameter int unsigned LOW_DG      = 10,
    parameter int unsigned EOC_DG      = 100,
    parameter int unsigned TEMP_DG     = 100,
    parameter int unsigned RECH_DG     = 1200,
    parameter int unsigned DEAD_DG     = 16000,
    parameter int unsigned PRE_TO      = 1800000,
    parameter int unsigned FAST_TO     = 18000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       in_ok,
    input  logic       chg_en,
    input  logic       term_en,
    input  logic       rech_en,
    input  logic       bat_lt_pre,
    input  logic       bat_at_float,
    input  logic       i_lt_term,
    input  logic       bat_lt_rech,
    input  logic       bat_lt_1v,
    input  logic       temp_bad,
    input  logic       die_warm,
    input  logic       ovchg,
    output logic [2:0] phase,
    output logic       half_cur,
    output logic       flag_pull_lo
);
    localparam int unsigned TMAX = (PRE_TO > FAST_TO) ? PRE_TO : FAST_TO;
    localparam int unsigned TW   = $clog2(TMAX + 1);
    localparam int unsigned DG_LEN [NUM_DG] =
        '{PRE_DG, LOW_DG, EOC_DG, TEMP_DG, RECH_DG, DEAD_DG};

    state_e            state, nxt;
    logic [NUM_DG-1:0] dg_cond, dg_arm, dg_done;
    logic [TW-1:0]     tmr;
    logic              charging, pause, tmo_hit, tmr_clr;
    phase_e            ph;
    flag_mode_e        fmode;
    blink_e            bsel;

    assign charging = (state == ST_PRE) || (state == ST_FAST) || (state == ST_CV);
    assign pause    = dg_done[DG_TEMP] && charging;

    // ---------------- deglitch filters ----------------
    always_comb begin
        dg_cond[DG_UP]   = !bat_lt_pre;
        dg_arm[DG_UP]    = (state == ST_PRE) && !pause;
        dg_cond[DG_LOW]  = bat_lt_pre;
        dg_arm[DG_LOW]   = ((state == ST_FAST) || (state == ST_CV)) && !pause;
        dg_cond[DG_EOC]  = i_lt_term && term_en;
        dg_arm[DG_EOC]   = (state == ST_CV) && !pause;
        dg_cond[DG_TEMP] = temp_bad;
        dg_arm[DG_TEMP]  = charging;
        dg_cond[DG_RECH] = bat_lt_rech && rech_en;
        dg_arm[DG_RECH]  = (state == ST_DONE);
        dg_cond[DG_DEAD] = bat_lt_1v;
        dg_arm[DG_DEAD]  = (state == ST_PRE);
    end

    for (genvar g = 0; g < NUM_DG; g++) begin : g_dg
        chg_dglt #(.LEN(DG_LEN[g])) u_dg (
            .clk  (clk),
            .rst_n(rst_n),
            .tick (tick),
            .arm  (dg_arm[g]),
            .cond (dg_cond[g]),
            .done (dg_done[g])
        );
    end

    // ---------------- timeout counter ----------------
    assign tmr_clr = (nxt != state) && ((nxt == ST_PRE) || (nxt == ST_FAST));

    chg_tmo #(.MAXV(TMAX)) u_tmo (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .clr  (tmr_clr),
        .run  (charging),
        .cnt  (tmr)
    );

    assign tmo_hit = ((state == ST_PRE) && tmr >= TW'(PRE_TO)) ||
                     (((state == ST_FAST) || (state == ST_CV)) && tmr >= TW'(FAST_TO));

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // ---------------- next state ----------------
    always_comb begin
        nxt = state;
        if (!in_ok) begin
            nxt = ST_IDLE;
        end else if (ovchg || state == ST_F_OVC) begin
            nxt = ST_F_OVC;
        end else if (!chg_en) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: nxt = bat_lt_pre ? ST_PRE : ST_FAST;
                ST_PRE: begin
                    if (tmo_hit)               nxt = ST_F_TO;
                    else if (dg_done[DG_DEAD]) nxt = ST_F_DEAD;
                    else if (dg_done[DG_UP])   nxt = ST_FAST;
                end
                ST_FAST: begin
                    if (tmo_hit)                    nxt = ST_F_TO;
                    else if (dg_done[DG_LOW])       nxt = ST_F_LOW;
                    else if (!pause && bat_at_float) nxt = ST_CV;
                end
                ST_CV: begin
                    if (tmo_hit)              nxt = ST_F_TO;
                    else if (dg_done[DG_LOW]) nxt = ST_F_LOW;
                    else if (dg_done[DG_EOC]) nxt = ST_DONE;
                end
                ST_DONE: begin
                    if (dg_done[DG_RECH]) nxt = bat_lt_pre ? ST_PRE : ST_FAST;
                end
                default: nxt = state;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        ph       = PH_OFF;
        half_cur = 1'b0;
        fmode    = FM_BLINK;
        bsel     = BL_CHG;
        unique case (state)
            ST_IDLE:  ph = PH_OFF;
            ST_PRE:   ph = pause ? PH_OFF : PH_PRE;
            ST_FAST:  ph = pause ? PH_OFF : PH_FAST;
            ST_CV:    ph = pause ? PH_OFF : PH_CV;
            ST_DONE:  ph = PH_DONE;
            default:  ph = PH_FAULT;
        endcase
        half_cur = die_warm && !pause && ((state == ST_PRE) || (state == ST_FAST));

        if (!in_ok) begin
            fmode = FM_REL;
        end else if (state == ST_F_DEAD || (!chg_en && state != ST_F_OVC)) begin
            fmode = FM_LOW;
        end else if (pause) begin
            bsel = BL_TEMP;
        end else if (die_warm && charging) begin
            bsel = BL_WARM;
        end else begin
            unique case (state)
                ST_F_LOW: bsel = BL_LOW;
                ST_F_TO:  bsel = BL_TO;
                ST_F_OVC: bsel = BL_OVC;
                ST_DONE:  bsel = BL_EOC;
                ST_PRE, ST_FAST, ST_CV: bsel = BL_CHG;
                default:  fmode = FM_REL;
            endcase
        end
    end

    assign phase = ph;

    chg_blink #(.TICKS_PER_S(TICKS_PER_S)) u_blink (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .mode   (fmode),
        .sel    (bsel),
        .pull_lo(flag_pull_lo)
    );

    // ---------------- assertions ----------------
    a_r1_off_without_input: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ok |=> (phase == PH_OFF));

    a_r10_ovc_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_F_OVC && in_ok) |=> (state == ST_F_OVC));

    a_r3_fast_after_filter: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAST && $past(state) == ST_PRE) |-> $past(dg_done[DG_UP]));

    a_r8_done_needs_term: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && $past(state) == ST_CV) |-> $past(term_en));

endmodule

// File: tb/chg_seq_ctrl_bench.sv
`timescale 1ns/1ps
module chg_seq_ctrl_bench;

    localparam int TPS     = 1000;
    localparam int PRE_DG  = 5;
    localparam int LOW_DG  = 3;
    localparam int EOC_DG  = 6;
    localparam int TEMP_DG = 4;
    localparam int RECH_DG = 8;
    localparam int DEAD_DG = 10;
    localparam int PRE_TO  = 1000;
    localparam int FAST_TO = 2000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1;
    logic in_ok = 1'b0, chg_en = 1'b1, term_en = 1'b1, rech_en = 1'b0;
    logic bat_lt_pre = 1'b1, bat_at_float = 1'b0, i_lt_term = 1'b0;
    logic bat_lt_rech = 1'b0, bat_lt_1v = 1'b0, temp_bad = 1'b0;
    logic die_warm = 1'b0, ovchg = 1'b0;
    logic [2:0] phase;
    logic half_cur, flag_pull_lo;

    int n_chk = 0, n_err = 0, cycle = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cycle <= cycle + 1;

    chg_seq_ctrl #(
        .TICKS_PER_S(TPS), .PRE_DG(PRE_DG), .LOW_DG(LOW_DG), .EOC_DG(EOC_DG),
        .TEMP_DG(TEMP_DG), .RECH_DG(RECH_DG), .DEAD_DG(DEAD_DG),
        .PRE_TO(PRE_TO), .FAST_TO(FAST_TO)
    ) u_chg_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .in_ok(in_ok), .chg_en(chg_en),
        .term_en(term_en), .rech_en(rech_en), .bat_lt_pre(bat_lt_pre),
        .bat_at_float(bat_at_float), .i_lt_term(i_lt_term), .bat_lt_rech(bat_lt_rech),
        .bat_lt_1v(bat_lt_1v), .temp_bad(temp_bad), .die_warm(die_warm), .ovchg(ovchg),
        .phase(phase), .half_cur(half_cur), .flag_pull_lo(flag_pull_lo)
    );

    function automatic int exp_half(int f10);
        return (TPS * 10) / (2 * f10);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cycle);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic meas(output int h);
        logic f0;
        int guard;
        h = 0;
        guard = 0;
        f0 = flag_pull_lo;
        while (flag_pull_lo == f0 && guard < 400) begin cyc(1); guard++; end
        f0 = flag_pull_lo;
        guard = 0;
        while (flag_pull_lo == f0 && guard < 400) begin cyc(1); h++; guard++; end
    endtask

    task automatic toggle_en();
        chg_en = 1'b0; cyc(3); chg_en = 1'b1; cyc(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycle, 0);
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int h, t0, lows;
        logic latch;
        cyc(1);
        chk(phase == 3'd0, "R1 reset phase", phase, 0);
        chk(flag_pull_lo == 1'b0, "R1 reset flag", flag_pull_lo, 0);
        chk(half_cur == 1'b0, "R1 reset half_cur", half_cur, 0);
        cyc(3); rst_n = 1'b1; cyc(3);
        chk(phase == 3'd0 && !flag_pull_lo, "R1 no input", phase, 0);

        // R2 start into pre-charge, R13 charging blink
        in_ok = 1'b1; cyc(2);
        chk(phase == 3'd1, "R2 start pre", phase, 1);
        meas(h); chk(h == exp_half(62), "R13 charging half period", h, exp_half(62));

        // R12 die warning, R13 priority of warning over charging
        die_warm = 1'b1; cyc(2);
        chk(half_cur == 1'b1, "R12 half_cur in pre", half_cur, 1);
        meas(h); chk(h == exp_half(142), "R13 warning half period", h, exp_half(142));
        die_warm = 1'b0; cyc(1);
        chk(half_cur == 1'b0, "R12 half_cur off", half_cur, 0);

        // R3 promotion deglitch
        bat_lt_pre = 1'b0; cyc(PRE_DG - 2); bat_lt_pre = 1'b1; cyc(3);
        chk(phase == 3'd1, "R3 short excursion ignored", phase, 1);
        bat_lt_pre = 1'b0; cyc(PRE_DG + 3);
        chk(phase == 3'd2, "R3 promote to fast", phase, 2);
        die_warm = 1'b1; cyc(1);
        chk(half_cur == 1'b1, "R12 half_cur in fast", half_cur, 1);
        die_warm = 1'b0;

        // R5 sag fault
        bat_lt_pre = 1'b1; cyc(LOW_DG - 1); bat_lt_pre = 1'b0; cyc(3);
        chk(phase == 3'd2, "R5 short dip ignored", phase, 2);
        bat_lt_pre = 1'b1; cyc(LOW_DG + 3);
        chk(phase == 3'd5, "R5 sag fault", phase, 5);
        meas(h); chk(h == exp_half(128), "R13 sag half period", h, exp_half(128));

        // R7 enable low
        chg_en = 1'b0; cyc(3);
        chk(phase == 3'd0, "R7 enable low phase", phase, 0);
        lows = 0;
        for (int i = 0; i < 20; i++) begin cyc(1); if (flag_pull_lo) lows++; end
        chk(lows == 20, "R7 flag steady low", lows, 20);
        t0 = cycle; chg_en = 1'b1; cyc(2);
        chk(phase == 3'd1, "R7 restart after sag", phase, 1);

        // R6 temperature pause
        temp_bad = 1'b1; cyc(TEMP_DG + 3);
        chk(phase == 3'd0, "R6 paused", phase, 0);
        meas(h); chk(h == exp_half(162), "R13 temperature half period", h, exp_half(162));
        temp_bad = 1'b0; cyc(3);
        chk(phase == 3'd1, "R6 resume pre", phase, 1);

        // R4 pre-charge timeout counts through pause
        while (cycle < t0 + PRE_TO - 10) cyc(1);
        chk(phase == 3'd1, "R4 before pre timeout", phase, 1);
        cyc(20);
        chk(phase == 3'd5, "R4 pre timeout", phase, 5);
        meas(h); chk(h == exp_half(102), "R13 timeout half period", h, exp_half(102));

        // R8 CV and termination
        bat_lt_pre = 1'b0; toggle_en();
        chk(phase == 3'd2, "R2 start fast", phase, 2);
        bat_at_float = 1'b1; cyc(2);
        chk(phase == 3'd3, "R8 enter cv", phase, 3);
        term_en = 1'b0; i_lt_term = 1'b1; cyc(40);
        chk(phase == 3'd3, "R8 termination disabled", phase, 3);
        term_en = 1'b1; cyc(EOC_DG + 3);
        chk(phase == 3'd4, "R8 done", phase, 4);
        meas(h); chk(h == exp_half(41), "R13 done half period", h, exp_half(41));

        // R9 recharge
        bat_at_float = 1'b0; i_lt_term = 1'b0;
        rech_en = 1'b0; bat_lt_rech = 1'b1; cyc(RECH_DG + 10);
        chk(phase == 3'd4, "R9 recharge disabled", phase, 4);
        rech_en = 1'b1; bat_lt_rech = 1'b0; cyc(2);
        bat_lt_rech = 1'b1; cyc(RECH_DG - 2); bat_lt_rech = 1'b0; cyc(3);
        chk(phase == 3'd4, "R9 short dip ignored", phase, 4);
        t0 = cycle; bat_lt_rech = 1'b1; cyc(RECH_DG + 4);
        chk(phase == 3'd2, "R9 recharge starts fast", phase, 2);
        bat_lt_rech = 1'b0;

        // R4 fast timeout
        while (cycle < t0 + FAST_TO - 10) cyc(1);
        chk(phase == 3'd2, "R4 before fast timeout", phase, 2);
        cyc(30);
        chk(phase == 3'd5, "R4 fast timeout", phase, 5);

        // R10 overcharge
        toggle_en();
        ovchg = 1'b1; cyc(2);
        chk(phase == 3'd5, "R10 overcharge fault", phase, 5);
        ovchg = 1'b0;
        meas(h); chk(h == exp_half(82), "R13 overcharge half period", h, exp_half(82));
        toggle_en();
        chk(phase == 3'd5, "R10 enable ignored", phase, 5);
        in_ok = 1'b0; cyc(2);
        chk(phase == 3'd0 && !flag_pull_lo, "R1 unplug clears", phase, 0);
        in_ok = 1'b1; cyc(2);
        chk(phase == 3'd2, "R10 replug charges", phase, 2);

        // R11 dead battery
        bat_lt_pre = 1'b1; bat_lt_1v = 1'b1; toggle_en();
        chk(phase == 3'd1, "R11 pre with dead battery", phase, 1);
        cyc(DEAD_DG + 3);
        chk(phase == 3'd5, "R11 dead fault", phase, 5);
        lows = 0;
        for (int i = 0; i < 40; i++) begin cyc(1); if (flag_pull_lo) lows++; end
        chk(lows == 40, "R11 flag steady low", lows, 40);
        bat_lt_1v = 1'b0;

        // random traffic
        void'($urandom(32'd7391));
        latch = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            cyc(1);
            latch = in_ok ? (latch | ovchg) : 1'b0;
            if (!in_ok) begin
                chk(phase == 3'd0, "R1 random unplug phase", phase, 0);
                chk(!flag_pull_lo, "R1 random unplug flag", flag_pull_lo, 0);
            end
            if (latch) chk(phase == 3'd5, "R10 random overcharge latched", phase, 5);
            if (half_cur) chk(die_warm, "R12 random half_cur", die_warm, 1);
            in_ok        = ($urandom % 10) != 0;
            chg_en       = ($urandom % 6) != 0;
            ovchg        = ($urandom % 60) == 0;
            tick         = $urandom % 2;
            bat_lt_pre   = $urandom % 2;
            bat_at_float = $urandom % 2;
            i_lt_term    = $urandom % 2;
            bat_lt_rech  = $urandom % 2;
            bat_lt_1v    = ($urandom % 4) == 0;
            temp_bad     = ($urandom % 3) == 0;
            die_warm     = $urandom % 2;
            term_en      = $urandom % 2;
            rech_en      = $urandom % 2;
        end

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule